// File: doc/BRIEF.md
# Polarity-Configurable Cascaded Interrupt Controller

This block is a secondary interrupt controller with registers that software can read and write. It gathers a parameterised set of peripheral interrupt lines, 18 by default, and drives one active-high summary request into a parent controller. Each input is first conditioned by its own polarity bit. The conditioned input is then captured into a sticky status register, using either level or edge capture. The captured bits are masked by a per-line enable, and the masked result is combined into the summary under a global enable bit.

Software reaches five 32-bit registers through a simple bus with a write strobe, an address and write data. Reads return data combinationally. A pending line is cleared by writing a one to its bit in a dedicated clear register. The parent treats the summary output as a level-high request.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, the control, enable, status and polarity registers all read 0, and `irq_out` is 0.
- R2: The registers sit at control 0x00, enable 0x04, status 0x08, clear 0x0C and polarity 0x10. In the control register, bit 31 is the global enable and bit 30 selects edge capture (0 = level). The other control bits read 0. The clear register and any unmapped offset read 0.
- R3: The enable and polarity registers hold bits 17:0, one bit per line. Bits 31:18 of the enable, status and polarity registers read 0 and ignore writes.
- R4: Writing a 1 to bit i at offset 0x0C clears status bit i. A 0 leaves the bit unchanged. Writes to offset 0x08 do not change the status register.
- R5: In level mode, a status bit is set on every clock edge at which its conditioned input is active. A clear written while the line is active has no effect.
- R6: In edge mode, a status bit is set on an inactive-to-active change of its conditioned input and stays set until cleared. It does not set again while the line stays active. When a set and a clear fall on the same edge, the set wins.
- R7: The conditioned input is the raw input XOR the polarity bit, so a polarity bit of 1 makes that line active-low.
- R8: `irq_out` is 1 exactly when control bit 31 is 1 and at least one line has both its status bit and its enable bit set. A status bit is captured whatever the state of its enable bit.
- R9: A register write takes effect on the clock edge that samples the write strobe. During the strobe cycle, a read of the same address still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_in | input | 18 | Peripheral interrupt lines, synchronous to `clk` |
| irq_out | output | 1 | Active-high summary request to the parent |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`, and that a write strobe carries a single address held for that cycle. The bench changes lines and bus signals only on the falling edge, and it drops the strobe after each write. The clear and capture properties compare each status bit with the conditioned input sampled one edge earlier. They therefore assume that polarity is never rewritten in the same cycle as a clear. The bench keeps these writes in separate cycles.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int N  = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [N-1:0]  irq_in,
  output logic          irq_out
);
  localparam logic [AW-1:0] OFF_CTL = AW'(8'h00);
  localparam logic [AW-1:0] OFF_EN  = AW'(8'h04);
  localparam logic [AW-1:0] OFF_STS = AW'(8'h08);
  localparam logic [AW-1:0] OFF_CLR = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_POL = AW'(8'h10);
  localparam int PAD = 32 - N;

  logic         glb_en, edge_mode;
  logic [N-1:0] en_q, pol_q, sts_q, cond_q;
  logic [N-1:0] cond, set_v, clr_v;
  logic         unused_wbits;

  assign unused_wbits = ^wdata[29:N];

  assign cond  = irq_in ^ pol_q;
  assign set_v = edge_mode ? (cond & ~cond_q) : cond;
  assign clr_v = (wr_en && addr == OFF_CLR) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en    <= 1'b0;
      edge_mode <= 1'b0;
      en_q      <= '0;
      pol_q     <= '0;
      sts_q     <= '0;
      cond_q    <= '0;
    end else begin
      cond_q <= cond;
      sts_q  <= set_v | (sts_q & ~clr_v);
      if (wr_en) begin
        if (addr == OFF_CTL) begin
          glb_en    <= wdata[31];
          edge_mode <= wdata[30];
        end
        if (addr == OFF_EN)  en_q  <= wdata[N-1:0];
        if (addr == OFF_POL) pol_q <= wdata[N-1:0];
      end
    end
  end

  always_comb begin
    case (addr)
      OFF_CTL: rdata = {glb_en, edge_mode, 30'd0};
      OFF_EN:  rdata = {{PAD{1'b0}}, en_q};
      OFF_STS: rdata = {{PAD{1'b0}}, sts_q};
      OFF_POL: rdata = {{PAD{1'b0}}, pol_q};
      default: rdata = 32'd0;
    endcase
  end

  assign irq_out = glb_en & |(sts_q & en_q);
endmodule

module cascade_irq_ctrl_chk #(
  parameter int N  = 18,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [N-1:0]  irq_in,
  input logic          irq_out,
  input logic [N-1:0]  sts,
  input logic [N-1:0]  pol,
  input logic          mode
);
  logic clr_wr;
  assign clr_wr = wr_en && addr == AW'(8'h0C);

  a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h00) && !wdata[31]) |=> !irq_out);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(8'h04) || addr == AW'(8'h08) || addr == AW'(8'h10)) |-> ((rdata >> N) == 32'd0));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((sts & $past(wdata[N-1:0]) & ~$past(irq_in ^ pol)) == '0));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(sts) & ~sts) == '0));

  a_r5_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> ((sts & $past(irq_in ^ pol)) == $past(irq_in ^ pol)));

  a_r8_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !irq_out);
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out),
  .sts(sts_q), .pol(pol_q), .mode(edge_mode)
);

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [17:0] irq_in = 0;
  logic        irq_out;
  int checks = 0, errors = 0;
  logic [31:0] d;

  cascade_irq_ctrl dut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .irq_in, .irq_out);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; wr_en = 0; #1 v = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 20; a += 4) begin
      rd(8'(a), d); chk("R1 reset read", d, 0);
    end
    chk("R1 reset irq_out", {31'd0, irq_out}, 0);
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 control bits", d, 32'hC000_0000);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R3 enable width", d, 32'h0003_FFFF);
    wr(8'h04, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 polarity width", d, 32'h0003_FFFF);
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'h0003_FFFF);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R4 status not writable", d, 0);
    rd(8'h0C, d); chk("R2 clear reads 0", d, 0);
    rd(8'h14, d); chk("R2 unmapped reads 0", d, 0);
  endtask

  task automatic t_timing;
    @(negedge clk); addr = 8'h04; wdata = 32'h15; wr_en = 1;
    #1 chk("R9 old value in strobe cycle", rdata, 0);
    @(negedge clk); wr_en = 0; #1 chk("R9 new value after edge", rdata, 32'h15);
    wr(8'h04, 0);
  endtask

  task automatic t_level;
    wr(8'h00, 32'h8000_0000); wr(8'h04, 32'h8);
    @(negedge clk); irq_in[3] = 1;
    @(negedge clk); irq_in[3] = 0; #1
    chk("R5 level capture irq_out", {31'd0, irq_out}, 1);
    rd(8'h08, d); chk("R5 status bit3 sticky", d, 32'h8);
    wr(8'h0C, 32'h0); rd(8'h08, d); chk("R4 zero write no effect", d, 32'h8);
    wr(8'h0C, 32'h8); rd(8'h08, d); chk("R4 clear bit3", d, 0);
    chk("R8 irq_out drops", {31'd0, irq_out}, 0);
    @(negedge clk); irq_in[5] = 1;
    cyc(1); wr(8'h0C, 32'h20); rd(8'h08, d); chk("R5 clear ignored while active", d, 32'h20);
    irq_in[5] = 0; cyc(1); wr(8'h0C, 32'h20); rd(8'h08, d); chk("R5 clear after drop", d, 0);
  endtask

  task automatic t_mask;
    wr(8'h04, 0);
    @(negedge clk); irq_in[7] = 1;
    @(negedge clk); irq_in[7] = 0; #1
    chk("R8 masked no irq", {31'd0, irq_out}, 0);
    rd(8'h08, d); chk("R8 capture while disabled", d, 32'h80);
    wr(8'h04, 32'h80); #1 chk("R8 enabled irq", {31'd0, irq_out}, 1);
    wr(8'h00, 32'h0); #1 chk("R8 global off", {31'd0, irq_out}, 0);
    wr(8'h0C, 32'h80); wr(8'h04, 0);
  endtask

  task automatic t_edge;
    wr(8'h00, 32'hC000_0000);
    @(negedge clk); irq_in[2] = 1;
    cyc(1); rd(8'h08, d); chk("R6 edge set", d, 32'h4);
    wr(8'h0C, 32'h4); cyc(2); rd(8'h08, d); chk("R6 no reset while held", d, 0);
    irq_in[2] = 0; cyc(2);
    @(negedge clk); irq_in[2] = 1; addr = 8'h0C; wdata = 32'h4; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(8'h08, d); chk("R6 set wins over clear", d, 32'h4);
    irq_in[2] = 0; cyc(1); wr(8'h0C, 32'h4);
    rd(8'h08, d); chk("R6 cleared after drop", d, 0);
  endtask

  task automatic t_pol;
    wr(8'h00, 32'h8000_0000); wr(8'h04, 32'h200);
    wr(8'h10, 32'h200); cyc(1);
    rd(8'h08, d); chk("R7 active-low line pending", d, 32'h200);
    chk("R7 irq_out", {31'd0, irq_out}, 1);
    irq_in[9] = 1; cyc(1); wr(8'h0C, 32'h200);
    rd(8'h08, d); chk("R7 high input inactive", d, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    t_reset; t_regs; t_timing; t_level; t_mask; t_edge; t_pol;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule